// File: doc/BRIEF.md
# Selector-Folded Function Lookup

This block evaluates any Boolean function of `NVARS` inputs with one selector of `2^(NVARS-1)` legs, not a full `2^NVARS` table. The upper `NVARS-1` inputs pick a leg. The lowest input, the "fold variable", is not used for selection. It feeds every leg, and each leg shows one of four values: constant zero, constant one, the fold variable, or its inverse.

Software, or a bench, works out the two-bit code for each leg from the truth table. For leg `i`, compare the function's values at fold variable 0 and fold variable 1 and pick the matching code. The codes are written one leg per cycle through a simple write port. The result is registered, and an enable input forces it low.

Top module: `fold_lut`

## Requirements
- R1: Reset (synchronous, active high) clears every leg code to zero. One cycle after reset, `fn_out` reads 0, and it stays 0 for every input pattern until a leg is written.
- R2: `vars_in[NVARS-1:1]` forms the leg index, with `vars_in[NVARS-1]` as its most significant bit. `vars_in[0]` is the fold variable.
- R3: Leg codes: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives the fold variable, and 2'b11 gives the inverted fold variable.
- R4: With codes derived from a truth table as described above, `fn_out` equals the function for every input pattern.
- R5: `fn_out` is registered. It shows the value for the inputs sampled at the previous rising clock edge, one new result per cycle, back to back.
- R6: When `fn_en` is low at a rising edge, `fn_out` is 0 after that edge, whatever the codes and inputs.
- R7: When `wr_en` is high at an edge, `wr_code` is stored at leg `wr_idx`. An evaluation in the same cycle still uses the old code. The new code applies from the next cycle, and other legs keep their codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one leg code this cycle |
| wr_idx | input | NVARS-1 | Leg to write |
| wr_code | input | 2 | Code to store |
| fn_en | input | 1 | Evaluation enable; low forces the output to 0 |
| vars_in | input | NVARS | Function inputs; bit 0 is the fold variable |
| fn_out | output | 1 | Registered function value |

## Verification
The bench drives every input pattern under several truth tables, including parity and one-hot functions. A leg-order or bit-mapping mistake would therefore give wrong values at mirrored indices. It steps one leg through all four codes with the fold variable at both levels, so swapped code meanings show up as inverted or stuck results.

It writes a leg while evaluating that same leg in the same cycle. A design that forwards the new code would give the new value one cycle early. It also applies reset in the middle of a run and then sweeps all inputs. A design that clears only the output and not the codes would keep giving ones.

// File: rtl/fold_lut_pkg.sv
package fold_lut_pkg;

  typedef enum logic [1:0] {
    LEG_ZERO = 2'b00,
    LEG_ONE  = 2'b01,
    LEG_VAR  = 2'b10,
    LEG_VARN = 2'b11
  } leg_code_e;

  function automatic logic leg_value(input logic [1:0] code, input logic x);
    case (leg_code_e'(code))
      LEG_ZERO: leg_value = 1'b0;
      LEG_ONE:  leg_value = 1'b1;
      LEG_VAR:  leg_value = x;
      default:  leg_value = ~x;
    endcase
  endfunction

endpackage

// File: rtl/fold_code_store.sv
module fold_code_store #(
  parameter int SELW = 3,
  localparam int LEGS = 1 << SELW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SELW-1:0]   wr_idx,
  input  logic [1:0]        wr_code,
  output logic [2*LEGS-1:0] codes_flat
);

  logic [1:0] code_q [LEGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LEGS; i++) code_q[i] <= 2'b00;
    end else if (wr_en) begin
      code_q[wr_idx] <= wr_code;
    end
  end

  for (genvar g = 0; g < LEGS; g++) begin : g_flat
    assign codes_flat[2*g +: 2] = code_q[g];
  end

endmodule

// File: rtl/fold_leg_gen.sv
module fold_leg_gen
  import fold_lut_pkg::*;
#(
  parameter int SELW = 3,
  localparam int LEGS = 1 << SELW
) (
  input  logic [2*LEGS-1:0] codes_flat,
  input  logic              fold_var,
  output logic [LEGS-1:0]   leg_bits
);

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    assign leg_bits[g] = leg_value(codes_flat[2*g +: 2], fold_var);
  end

endmodule

// File: rtl/fold_sel_tree.sv
module fold_sel_tree #(
  parameter int SELW = 3,
  localparam int LEGS  = 1 << SELW,
  localparam int NODES = 2 * LEGS - 1
) (
  input  logic [LEGS-1:0] leg_bits,
  input  logic [SELW-1:0] sel,
  output logic            picked
);

  logic [NODES-1:0] node;

  for (genvar i = 0; i < LEGS; i++) begin : g_leaf
    assign node[LEGS-1+i] = leg_bits[i];
  end

  for (genvar d = 0; d < SELW; d++) begin : g_lvl
    for (genvar j = 0; j < (1 << d); j++) begin : g_node
      localparam int K = (1 << d) - 1 + j;
      assign node[K] = sel[SELW-1-d] ? node[2*K+2] : node[2*K+1];
    end
  end

  assign picked = node[0];

endmodule

// File: rtl/fold_lut.sv
module fold_lut #(
  parameter int NVARS = 4,
  localparam int SELW = NVARS - 1,
  localparam int LEGS = 1 << SELW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SELW-1:0]  wr_idx,
  input  logic [1:0]       wr_code,
  input  logic             fn_en,
  input  logic [NVARS-1:0] vars_in,
  output logic             fn_out
);

  logic [2*LEGS-1:0] codes_flat;
  logic [LEGS-1:0]   leg_bits;
  logic              picked;

  fold_code_store #(.SELW(SELW)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_code(wr_code), .codes_flat(codes_flat)
  );

  fold_leg_gen #(.SELW(SELW)) u_legs (
    .codes_flat(codes_flat), .fold_var(vars_in[0]), .leg_bits(leg_bits)
  );

  fold_sel_tree #(.SELW(SELW)) u_tree (
    .leg_bits(leg_bits), .sel(vars_in[NVARS-1:1]), .picked(picked)
  );

  always_ff @(posedge clk) begin
    if (rst) fn_out <= 1'b0;
    else     fn_out <= fn_en & picked;
  end

endmodule

// File: rtl/fold_lut_chk.sv
module fold_lut_chk #(
  parameter int NVARS = 4,
  localparam int SELW = NVARS - 1,
  localparam int LEGS = 1 << SELW
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [SELW-1:0]   wr_idx,
  input logic [1:0]        wr_code,
  input logic              fn_en,
  input logic [NVARS-1:0]  vars_in,
  input logic [2*LEGS-1:0] codes_flat,
  input logic              fn_out
);

  logic [1:0]      cur_code;
  logic            pw_vld;
  logic [SELW-1:0] pw_idx;
  logic [1:0]      pw_code;

  assign cur_code = codes_flat[2*vars_in[NVARS-1:1] +: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      pw_vld  <= 1'b0;
      pw_idx  <= '0;
      pw_code <= 2'b00;
    end else begin
      pw_vld  <= wr_en;
      pw_idx  <= wr_idx;
      pw_code <= wr_code;
    end
  end

  AST_RESET_OUT_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> fn_out == 1'b0); // R1

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    !fn_en |=> fn_out == 1'b0); // R6

  AST_LEG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (fn_en && cur_code == 2'b00) |=> fn_out == 1'b0); // R3

  AST_LEG_ONE: assert property (@(posedge clk) disable iff (rst)
    (fn_en && cur_code == 2'b01) |=> fn_out == 1'b1); // R3

  AST_LEG_VAR: assert property (@(posedge clk) disable iff (rst)
    (fn_en && cur_code == 2'b10) |=> fn_out == $past(vars_in[0])); // R3

  AST_LEG_VARN: assert property (@(posedge clk) disable iff (rst)
    (fn_en && cur_code == 2'b11) |=> fn_out != $past(vars_in[0])); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    pw_vld |-> codes_flat[2*pw_idx +: 2] == pw_code); // R7

endmodule

bind fold_lut fold_lut_chk #(.NVARS(NVARS)) u_fold_lut_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_code(wr_code),
  .fn_en(fn_en), .vars_in(vars_in), .codes_flat(codes_flat), .fn_out(fn_out)
);

// File: tb/fold_lut_bench.sv
`timescale 1ns/1ps
module fold_lut_bench;

  localparam int NV = 4;
  localparam int NL = 1 << (NV - 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [NV-2:0] wr_idx = '0;
  logic [1:0]    wr_code = 2'b00;
  logic          fn_en = 1'b0;
  logic [NV-1:0] vars_in = '0;
  logic          fn_out;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sb[$];

  logic [1:0] model [NL];

  always #10 clk = ~clk;

  fold_lut #(.NVARS(NV)) u_fold_lut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_code(wr_code),
    .fn_en(fn_en), .vars_in(vars_in), .fn_out(fn_out)
  );

  function automatic logic code_val(input logic [1:0] c, input logic x);
    if (c == 2'b00) return 1'b0;
    if (c == 2'b01) return 1'b1;
    if (c == 2'b10) return x;
    return ~x;
  endfunction

  function automatic logic [1:0] fold_code(input logic f0, input logic f1);
    if (!f0 && !f1) return 2'b00;
    if (f0 && f1)   return 2'b01;
    if (!f0 && f1)  return 2'b10;
    return 2'b11;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: fn_out=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // driver: one input cycle, expectation pushed to scoreboard
  task automatic drive(input logic [NV-1:0] v, input logic en, input logic we,
                       input logic [NV-2:0] idx, input logic [1:0] code,
                       input logic exp, input string tag);
    item_t it;
    @(negedge clk);
    vars_in = v; fn_en = en; wr_en = we; wr_idx = idx; wr_code = code;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    if (we) model[idx] = code;
  endtask

  function automatic logic model_eval(input logic [NV-1:0] v);
    return code_val(model[v[NV-1:1]], v[0]);
  endfunction

  task automatic load_tt(input logic [15:0] tt);
    for (int i = 0; i < NL; i++)
      drive('0, 1'b0, 1'b1, i[NV-2:0], fold_code(tt[2*i], tt[2*i+1]), 1'b0, "R6");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; fn_en = 1'b0;
    end
  endtask

  // monitor: compare one result per cycle after each edge
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(fn_out, it.exp, it.tag);
    end
  end

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] tts [4];
    tts[0] = 16'h6996; tts[1] = 16'hA5C3; tts[2] = 16'hE817; tts[3] = 16'h0001;
    for (int i = 0; i < NL; i++) model[i] = 2'b00;

    repeat (3) @(negedge clk);
    check(fn_out, 1'b0, "R1 in reset");
    rst = 1'b0;

    // R1: codes cleared after reset
    for (int v = 0; v < 16; v++) drive(v[NV-1:0], 1'b1, 1'b0, '0, 2'b00, 1'b0, "R1");

    // R3: every code on leg 5, fold variable at both levels
    for (int c = 0; c < 4; c++) begin
      drive('0, 1'b0, 1'b1, 3'd5, c[1:0], 1'b0, "R6");
      drive({3'd5, 1'b0}, 1'b1, 1'b0, '0, 2'b00, code_val(c[1:0], 1'b0), "R3");
      drive({3'd5, 1'b1}, 1'b1, 1'b0, '0, 2'b00, code_val(c[1:0], 1'b1), "R3");
    end

    // R2: leg 4 (MSB select) distinct from leg 1
    drive('0, 1'b0, 1'b1, 3'd5, 2'b00, 1'b0, "R6");
    drive('0, 1'b0, 1'b1, 3'd4, 2'b01, 1'b0, "R6");
    drive(4'b1000, 1'b1, 1'b0, '0, 2'b00, 1'b1, "R2");
    drive(4'b0010, 1'b1, 1'b0, '0, 2'b00, 1'b0, "R2");
    drive(4'b1001, 1'b1, 1'b0, '0, 2'b00, 1'b1, "R2");
    drive(4'b0001, 1'b1, 1'b0, '0, 2'b00, 1'b0, "R2");

    // R4: several truth tables, full sweep
    for (int t = 0; t < 4; t++) begin
      load_tt(tts[t]);
      for (int v = 0; v < 16; v++)
        drive(v[NV-1:0], 1'b1, 1'b0, '0, 2'b00, tts[t][v], "R4");
    end

    // R5: back-to-back results in gray order on parity
    load_tt(16'h6996);
    for (int v = 0; v < 16; v++) begin
      logic [3:0] gv;
      gv = v[3:0] ^ (v[3:0] >> 1);
      drive(gv, 1'b1, 1'b0, '0, 2'b00, ^gv, "R5");
    end

    // R6: enable low forces zero with all-ones function
    load_tt(16'hFFFF);
    drive(4'b0110, 1'b0, 1'b0, '0, 2'b00, 1'b0, "R6");
    drive(4'b1111, 1'b1, 1'b0, '0, 2'b00, 1'b1, "R6");
    drive(4'b1011, 1'b0, 1'b0, '0, 2'b00, 1'b0, "R6");
    drive(4'b0000, 1'b1, 1'b0, '0, 2'b00, 1'b1, "R6");

    // R7: write and evaluate the same leg in one cycle
    drive({3'd3, 1'b0}, 1'b1, 1'b1, 3'd3, 2'b00, 1'b1, "R7 old code");
    drive({3'd3, 1'b0}, 1'b1, 1'b0, '0, 2'b00, 1'b0, "R7 new code");
    drive({3'd2, 1'b1}, 1'b1, 1'b0, '0, 2'b00, 1'b1, "R7 other leg");
    drive({3'd3, 1'b1}, 1'b1, 1'b0, '0, 2'b00, model_eval({3'd3, 1'b1}), "R7");

    // R1: reset mid-run clears codes
    idle(3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int i = 0; i < NL; i++) model[i] = 2'b00;
    for (int v = 0; v < 16; v++) drive(v[NV-1:0], 1'b1, 1'b0, '0, 2'b00, 1'b0, "R1 after reset");

    idle(4);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule